// File: doc/BRIEF.md
# Dual-Channel Serial Converter Input Register

This block is the digital front end of a two-channel, 12-bit serial-input converter, written as a synchronous model. The four serial control inputs (select, serial clock, serial data and load) are asynchronous to the system clock. Each passes through a two-flop synchronizer, and the block then detects rising and falling edges on the synchronized levels. While select is low, a 24-bit shift register takes in one data bit on each rising edge of the serial clock. One frame carries both channel codes, and it arrives most significant bit first. Channel B occupies the first 12 bits and channel A the last 12.

The two 12-bit holding registers take the shifted word in one of two ways. With load held low, they update when select rises. With load held high during the frame, they update when load later falls. A one-cycle strobe marks every update. A serial output repeats the bit that was shifted in 24 serial-clock edges earlier and changes on falling serial-clock edges. Devices can therefore be cascaded, or the last frame can be read back. The output-enable flag stands in for the pad's high-impedance state while the block is deselected.

The system clock must run at least four times faster than the serial clock.

Top module: `dual_dac_frontend`

## Requirements
- R1: While reset is high, both channel codes are zero, the update strobe is low, the serial output is 0 and its enable is low.
- R2: The word shifted in during one select-low window is applied as follows. The first 12 bits received, MSB first, become the channel B code. The last 12 bits become the channel A code.
- R3: Serial-clock edges and data seen while select is high leave the shift register unchanged. A later load then applies the earlier word.
- R4: In three-wire mode (load low), both codes update together when select rises.
- R5: When select rises while load is high, no update occurs and the codes keep their values. The next falling edge of load applies the shifted word.
- R6: While select is low, the serial output shows the bit received 24 rising serial-clock edges earlier. It is valid from the fall of select and changes only after falling serial-clock edges.
- R7: The serial-output enable is high while select is low and low while select is high.
- R8: The update strobe is high for exactly one cycle per update. The codes change only in a cycle where the strobe is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_n_i | input | 1 | Frame select, active low, asynchronous |
| ser_clk_i | input | 1 | Serial bit clock, asynchronous |
| ser_in_i | input | 1 | Serial data input |
| load_n_i | input | 1 | Update control, active low; tied low for three-wire mode |
| ser_out_o | output | 1 | Delayed serial output for cascading and read-back |
| ser_out_en_o | output | 1 | Serial-output enable (low means high impedance) |
| code_a_o | output | 12 | Channel A holding register |
| code_b_o | output | 12 | Channel B holding register |
| update_o | output | 1 | One-cycle pulse when the holding registers load |

## Verification
Four properties are checked on every cycle:
- The codes never move outside a strobe cycle.
- The strobe follows only a cycle in which load was seen low.
- The shift register holds still whenever the synchronized select is high.
- The output enable is low after select has stayed high for four cycles.

Only the bench scenarios can show the rest:
- The channel order within a frame.
- The 24-edge delay of the serial output.
- The pending behaviour of four-wire mode, where a select rise under a high load is skipped and the next load fall applies the word.
- That deselected serial-clock activity leaves no trace in a later update.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
  // Bit positions of the control inputs inside the synchronizer bundle
  localparam int IDX_SEL  = 0;
  localparam int IDX_LOAD = 1;
  localparam int IDX_CLK  = 2;
  localparam int IDX_DAT  = 3;
  localparam int NUM_IN   = 4;
  // Idle levels after reset: select high (deselected), others low
  localparam logic [NUM_IN-1:0] IN_IDLE = 4'b0001;
  // Channel indices within a frame word: A is the low slice, B the high
  localparam int CH_A   = 0;
  localparam int CH_B   = 1;
  localparam int NUM_CH = 2;
endpackage

// File: rtl/dacfe_sync.sv
module dacfe_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] IDLE = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] stg [STAGES];
  logic [W-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= IDLE;
      prev <= IDLE;
    end else begin
      stg[0] <= async_i;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      prev <= stg[STAGES-1];
    end
  end

  assign lvl_o  = stg[STAGES-1];
  assign rise_o = stg[STAGES-1] & ~prev;
  assign fall_o = ~stg[STAGES-1] & prev;
endmodule

// File: rtl/dacfe_shift.sv
module dacfe_shift #(
  parameter int FRAME_W = 24
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sel_lvl,
  input  logic               sel_fall,
  input  logic               bit_rise,
  input  logic               bit_fall,
  input  logic               dat,
  output logic [FRAME_W-1:0] word_o,
  output logic               ser_o,
  output logic               oe_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      word_o <= '0;
      ser_o  <= 1'b0;
      oe_o   <= 1'b0;
    end else begin
      oe_o <= ~sel_lvl;
      if (bit_rise && !sel_lvl)
        word_o <= {word_o[FRAME_W-2:0], dat};
      // present the oldest bit when selected and after each falling edge
      if (sel_fall || (bit_fall && !sel_lvl))
        ser_o <= word_o[FRAME_W-1];
    end
  end
endmodule

// File: rtl/dacfe_hold.sv
module dacfe_hold #(
  parameter int CODE_W = 12,
  parameter int NUM_CH = 2,
  localparam int FRAME_W = CODE_W * NUM_CH
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sel_rise,
  input  logic               load_lvl,
  input  logic               load_fall,
  input  logic [FRAME_W-1:0] word_i,
  output logic [CODE_W-1:0]  code_o [NUM_CH],
  output logic               strobe_o
);
  logic fire;
  // a load fall always leaves load low; a select rise counts only under low load
  assign fire = !load_lvl && (sel_rise || load_fall);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst)       code_o[c] <= '0;
      else if (fire) code_o[c] <= word_i[c*CODE_W +: CODE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) strobe_o <= 1'b0;
    else     strobe_o <= fire;
  end
endmodule

// File: rtl/dual_dac_frontend.sv
module dual_dac_frontend #(
  parameter int CODE_W = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_n_i,
  input  logic              ser_clk_i,
  input  logic              ser_in_i,
  input  logic              load_n_i,
  output logic              ser_out_o,
  output logic              ser_out_en_o,
  output logic [CODE_W-1:0] code_a_o,
  output logic [CODE_W-1:0] code_b_o,
  output logic              update_o
);
  import dacfe_pkg::*;
  localparam int FRAME_W = CODE_W * NUM_CH;

  logic [NUM_IN-1:0] raw, lvl, rise, fall;
  logic [FRAME_W-1:0] word;
  logic [CODE_W-1:0] code [NUM_CH];
  logic sel_lvl, load_lvl;
  logic unused_edges;

  always_comb begin
    raw = '0;
    raw[IDX_SEL]  = sel_n_i;
    raw[IDX_LOAD] = load_n_i;
    raw[IDX_CLK]  = ser_clk_i;
    raw[IDX_DAT]  = ser_in_i;
  end

  dacfe_sync #(.W(NUM_IN), .STAGES(SYNC_STAGES), .IDLE(IN_IDLE)) u_sync (
    .clk(clk), .rst(rst), .async_i(raw),
    .lvl_o(lvl), .rise_o(rise), .fall_o(fall)
  );

  assign sel_lvl  = lvl[IDX_SEL];
  assign load_lvl = lvl[IDX_LOAD];
  assign unused_edges = &{1'b0, lvl[IDX_CLK], rise[IDX_DAT], fall[IDX_DAT],
                          rise[IDX_LOAD]};

  dacfe_shift #(.FRAME_W(FRAME_W)) u_shift (
    .clk(clk), .rst(rst),
    .sel_lvl(sel_lvl), .sel_fall(fall[IDX_SEL]),
    .bit_rise(rise[IDX_CLK]), .bit_fall(fall[IDX_CLK]),
    .dat(lvl[IDX_DAT]),
    .word_o(word), .ser_o(ser_out_o), .oe_o(ser_out_en_o)
  );

  dacfe_hold #(.CODE_W(CODE_W), .NUM_CH(NUM_CH)) u_hold (
    .clk(clk), .rst(rst),
    .sel_rise(rise[IDX_SEL]), .load_lvl(load_lvl), .load_fall(fall[IDX_LOAD]),
    .word_i(word), .code_o(code), .strobe_o(update_o)
  );

  assign code_a_o = code[CH_A];
  assign code_b_o = code[CH_B];
endmodule

// File: rtl/dacfe_checker.sv
module dacfe_checker #(
  parameter int CODE_W = 12,
  localparam int FRAME_W = 2 * CODE_W
) (
  input logic              clk,
  input logic              rst,
  input logic              sel_n_i,
  input logic              ser_out_en_o,
  input logic              update_o,
  input logic [CODE_W-1:0] code_a_o,
  input logic [CODE_W-1:0] code_b_o,
  input logic              sel_lvl,
  input logic              load_lvl,
  input logic [FRAME_W-1:0] word
);
  assert_codes_move_on_strobe_R8: assert property (@(posedge clk) disable iff (rst)
    !$stable({code_b_o, code_a_o}) |-> update_o);

  assert_update_needs_low_load_R5: assert property (@(posedge clk) disable iff (rst)
    update_o |-> !$past(load_lvl));

  assert_no_shift_deselected_R3: assert property (@(posedge clk) disable iff (rst)
    sel_lvl |=> $stable(word));

  assert_oe_off_when_deselected_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(sel_n_i, 1) && $past(sel_n_i, 2) && $past(sel_n_i, 3) && $past(sel_n_i, 4))
    |-> !ser_out_en_o);
endmodule

bind dual_dac_frontend dacfe_checker #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst(rst), .sel_n_i(sel_n_i), .ser_out_en_o(ser_out_en_o),
  .update_o(update_o), .code_a_o(code_a_o), .code_b_o(code_b_o),
  .sel_lvl(sel_lvl), .load_lvl(load_lvl), .word(word)
);

// File: tb/tb_dual_dac_frontend.sv
module tb_dual_dac_frontend;
  localparam int CW = 12;
  localparam int FW = 2 * CW;
  localparam int HALF = 5;

  logic clk = 0, rst = 1;
  logic sel_n = 1, sclk = 0, sdin = 0, load_n = 0;
  logic sout, sout_en, upd;
  logic [CW-1:0] ca, cb;

  int checks = 0, errors = 0, strobes = 0;
  bit done = 0;
  logic [FW-1:0] exp_q[$];
  logic [FW-1:0] prev_word = '0;
  logic prev_upd = 0;

  always #4 clk = ~clk;

  dual_dac_frontend dut (
    .clk(clk), .rst(rst), .sel_n_i(sel_n), .ser_clk_i(sclk), .ser_in_i(sdin),
    .load_n_i(load_n), .ser_out_o(sout), .ser_out_en_o(sout_en),
    .code_a_o(ca), .code_b_o(cb), .update_o(upd)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: every strobe pops one expected word (B in high half, A in low)
  always @(negedge clk) begin
    if (!rst) begin
      if (upd) begin
        strobes++;
        check(!prev_upd, "R8 strobe width", 2, 1);
        if (exp_q.size() == 0) check(0, "R8 unexpected update", {cb, ca}, 0);
        else begin
          logic [FW-1:0] e;
          e = exp_q.pop_front();
          check(cb == e[FW-1:CW], "R2 channel B code", cb, e[FW-1:CW]);
          check(ca == e[CW-1:0], "R2 channel A code", ca, e[CW-1:0]);
        end
      end
      prev_upd = upd;
    end
  end

  // sends one frame; serial output is checked against the previous frame (R6)
  task automatic send(input logic [FW-1:0] w);
    sel_n = 0;
    for (int k = 0; k < FW; k++) begin
      sdin = w[FW-1-k];
      tick(HALF);
      if (k == 0) check(sout_en == 1, "R7 enable while selected", sout_en, 1);
      check(sout == prev_word[FW-1-k], "R6 delayed serial output", sout,
            prev_word[FW-1-k]);
      sclk = 1;
      tick(HALF);
      sclk = 0;
    end
    tick(HALF);
    if (load_n == 0) exp_q.push_back(w);
    sel_n = 1;
    prev_word = w;
    tick(8);
    check(sout_en == 0, "R7 enable off when deselected", sout_en, 0);
  endtask

  initial begin
    tick(5);
    check(ca == 0 && cb == 0, "R1 codes zero in reset", {cb, ca}, 0);
    check(sout_en == 0 && sout == 0, "R1 serial output off", {sout_en, sout}, 0);
    check(upd == 0, "R1 strobe low", upd, 0);
    rst = 0;
    tick(6);

    // R4 three-wire updates on select rise
    send({12'hA5C, 12'h3F1});
    check(exp_q.size() == 0, "R4 update on select rise", exp_q.size(), 0);
    send({12'h5A3, 12'h0C7});
    check(exp_q.size() == 0, "R4 second frame", exp_q.size(), 0);
    check(strobes == 2, "R8 one strobe per update", strobes, 2);

    // R3 serial activity while deselected is ignored
    for (int i = 0; i < 10; i++) begin
      sdin = i[0]; sclk = 1; tick(HALF); sclk = 0; tick(HALF);
    end
    load_n = 1; tick(8);
    exp_q.push_back(prev_word);
    load_n = 0; tick(8);
    check(exp_q.size() == 0, "R3 reload of unchanged word", exp_q.size(), 0);
    check({cb, ca} == {12'h5A3, 12'h0C7}, "R3 word unchanged", {cb, ca},
          {12'h5A3, 12'h0C7});

    // R5 four-wire: select rise with load high does nothing, load fall applies
    load_n = 1; tick(8);
    send({12'hFFF, 12'h000});
    check(strobes == 3, "R5 no update on select rise", strobes, 3);
    check({cb, ca} == {12'h5A3, 12'h0C7}, "R5 codes held", {cb, ca},
          {12'h5A3, 12'h0C7});
    exp_q.push_back({12'hFFF, 12'h000});
    load_n = 0; tick(8);
    check(exp_q.size() == 0, "R5 update on load fall", exp_q.size(), 0);

    load_n = 1; tick(8);
    send({12'h800, 12'h001});
    exp_q.push_back({12'h800, 12'h001});
    load_n = 0; tick(8);
    check(exp_q.size() == 0, "R5 second four-wire frame", exp_q.size(), 0);

    // R6 read back the last frame through a three-wire frame
    send({12'h123, 12'h456});
    check(strobes == 6, "R8 total strobes", strobes, 6);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule